// File: doc/BRIEF.md
# SPI Command Frame Decoder for an SPI-to-I2C Bridge

This block is the SPI slave front end of a bridge that lets an SPI host drive an I2C bus. The host lowers chip select, clocks in an opcode byte and the header bytes that belong to that opcode, and then raises chip select. Transfer commands carry lengths and I2C address bytes, and write commands also carry payload bytes. The payload bytes go into a shared data buffer that the I2C engine reads. Register commands read or write a small file of configuration and status bytes. A buffer-read command streams back the bytes that the engine left in the buffer.

The block does not drive the I2C bus itself. When chip select rises after a complete transfer frame, it issues a one-cycle job descriptor to the engine. The descriptor gives the operation kind, both lengths and both address bytes. A frame cut short by chip select is dropped. A length that does not fit the buffer is refused: no job is issued, and the status byte takes the size-error code. The SPI pins are oversampled on the system clock through synchronisers, so the SPI clock must be several times slower than the system clock.

Top module: `spi_cmd_bridge`

## Requirements
- R1: SPI runs in mode 3. The pins idle with the clock high, MOSI is sampled on the rising edge and MISO changes on the falling edge. Bytes are 8 bits, MSB first. Opcode 0x20 followed by an index and a value writes the register at that index. Opcode 0x21 followed by an index returns that register on the next byte. Register byte i appears at `cfg_regs[8*i+7:8*i]`.
- R2: Register index 4 is the status byte. SPI writes to it are ignored. The engine sets it through `stat_we`/`stat_val`, and 0x21 reads back the current value.
- R3: Opcode 0x00 is followed by a length L, an address byte and L data bytes. The data bytes are stored at buffer index 0 onward. Raising chip select then issues a job with kind 0, len1 = L, len2 = 0, addr2 = 0.
- R4: Opcode 0x01 is followed by a length and an address byte only. It issues a job with kind 1, len1 = length, len2 = 0, addr2 = 0.
- R5: Opcode 0x02 is followed by a write length, a read length, the first address byte, the write data and then a second address byte. It issues a job with kind 2, carrying both lengths and both address bytes.
- R6: Opcode 0x03 is followed by len1, len2, addr1, data1, addr2, data2. data1 is stored from index 0 and data2 from index len1. It issues a job with kind 3.
- R7: A transfer is refused when any length exceeds 96, or, for kind 3, when len1 + len2 exceeds 96. A refused transfer issues no job and sets the status byte to 0xF9.
- R8: When chip select rises before a transfer frame is complete, the frame is discarded. No job is issued and the status byte is left unchanged.
- R9: Opcode 0x06 returns buffer bytes 0, 1, 2, … on the bytes that follow the opcode, one byte per clocked byte.
- R10: MISO carries 0x00 on every byte with no defined response. This covers the opcode byte, and register reads of an index above 5.
- R11: `job_valid` is a single-cycle pulse, and the job fields stay stable after it until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI clock from the host |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the host |
| spi_miso | output | 1 | SPI data to the host |
| job_valid | output | 1 | One-cycle pulse: a transfer job is ready |
| job_kind | output | 2 | 0 write, 1 read, 2 write-then-read, 3 write-then-write |
| job_len1 | output | 8 | First message length |
| job_len2 | output | 8 | Second message length |
| job_addr1 | output | 8 | First address byte |
| job_addr2 | output | 8 | Second address byte |
| eng_raddr | input | 7 | Engine buffer read index |
| eng_rdata | output | 8 | Buffer byte at `eng_raddr` (combinational) |
| eng_we | input | 1 | Engine buffer write enable |
| eng_waddr | input | 7 | Engine buffer write index |
| eng_wdata | input | 8 | Engine buffer write data |
| stat_we | input | 1 | Engine status write enable |
| stat_val | input | 8 | Engine status value |
| cfg_regs | output | 48 | All register bytes, index 0 in the low byte |

## Verification
Each result becomes visible at its own fixed delay. `job_valid` rises three system cycles after chip select rises: two synchroniser flops, then the decoder register. A MISO bit is valid about three cycles after the falling SPI edge that launches it. A register write shows on `cfg_regs` a few cycles after the last rising edge of its value byte. The bench drives each SPI half period for eight system cycles. It samples MISO just before raising the clock, and it checks the expected-job queue for emptiness only after chip select has been high for sixteen cycles. A monitor compares every pulse on `job_valid` against the queued expectation in the cycle it occurs. Any pulse with nothing queued is counted as a failure, and so is a pulse that lasts two cycles.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;
    typedef enum logic [1:0] {
        JK_WR   = 2'd0,
        JK_RD   = 2'd1,
        JK_WRRD = 2'd2,
        JK_WRWR = 2'd3
    } job_kind_e;

    typedef enum logic [3:0] {
        ST_OP, ST_LEN1, ST_LEN2, ST_ADDR1, ST_DATA1, ST_ADDR2, ST_DATA2,
        ST_REGW_IDX, ST_REGW_VAL, ST_REGR_IDX, ST_REGR_OUT, ST_RDBUF, ST_IGNORE
    } dec_state_e;

    localparam logic [7:0] OPC_WR    = 8'h00;
    localparam logic [7:0] OPC_RD    = 8'h01;
    localparam logic [7:0] OPC_WRRD  = 8'h02;
    localparam logic [7:0] OPC_WRWR  = 8'h03;
    localparam logic [7:0] OPC_RDBUF = 8'h06;
    localparam logic [7:0] OPC_REGW  = 8'h20;
    localparam logic [7:0] OPC_REGR  = 8'h21;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic csn_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic cs_rise,
    output logic mosi_s
);
    // bit 2 sck, bit 1 csn, bit 0 mosi; both clock and select idle high
    localparam logic [2:0] IDLE = 3'b110;
    logic [2:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= IDLE;
            s2_q <= IDLE;
            s3_q <= IDLE;
        end else begin
            s1_q <= {sck_i, csn_i, mosi_i};
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign sck_rise = s2_q[2] & ~s3_q[2];
    assign sck_fall = ~s2_q[2] & s3_q[2];
    assign cs_act   = ~s2_q[1];
    assign cs_rise  = s2_q[1] & ~s3_q[1];
    assign mosi_s   = s2_q[0];
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs #(
    parameter int         NREG     = 6,
    parameter int         STAT_IDX = 4,
    parameter logic [7:0] SIZE_ERR = 8'hF9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_idx,
    input  logic [7:0]        reg_wdata,
    input  logic              stat_set,
    input  logic              stat_we,
    input  logic [7:0]        stat_val,
    output logic [7:0]        reg_rdata,
    output logic [NREG*8-1:0] regs_flat
);
    logic [7:0] regs_d [NREG];
    logic [7:0] regs_q [NREG];

    always_comb begin
        reg_rdata = 8'h00;
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
            if (reg_we && reg_idx == 8'(i) && i != STAT_IDX) regs_d[i] = reg_wdata;
            if (reg_idx == 8'(i)) reg_rdata = regs_q[i];
        end
        if (stat_set)     regs_d[STAT_IDX] = SIZE_ERR;
        else if (stat_we) regs_d[STAT_IDX] = stat_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= 8'h00;
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_flat[g*8 +: 8] = regs_q[g];
    end
endmodule

// File: rtl/spi_data_buf.sv
module spi_data_buf #(
    parameter int DEPTH = 96,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_waddr,
    input  logic [7:0]    a_wdata,
    input  logic [AW-1:0] a_raddr,
    output logic [7:0]    a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_waddr,
    input  logic [7:0]    b_wdata,
    input  logic [AW-1:0] b_raddr,
    output logic [7:0]    b_rdata
);
    logic [7:0] mem_q [DEPTH];

    // port a (SPI side) wins a same-cycle collision
    always_ff @(posedge clk) begin
        if (a_we && int'(a_waddr) < DEPTH)      mem_q[a_waddr] <= a_wdata;
        else if (b_we && int'(b_waddr) < DEPTH) mem_q[b_waddr] <= b_wdata;
    end

    assign a_rdata = (int'(a_raddr) < DEPTH) ? mem_q[a_raddr] : 8'h00;
    assign b_rdata = (int'(b_raddr) < DEPTH) ? mem_q[b_raddr] : 8'h00;
endmodule

// File: rtl/spi_frame_decoder.sv
module spi_frame_decoder
    import spi_bridge_pkg::*;
#(
    parameter int DEPTH = 96,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          cs_rise,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          mosi_s,
    input  logic [7:0]    reg_rdata,
    input  logic [7:0]    buf_rdata,
    output logic          miso,
    output logic [7:0]    reg_idx,
    output logic          reg_we,
    output logic [7:0]    reg_wdata,
    output logic          stat_set,
    output logic          buf_we,
    output logic [AW-1:0] buf_waddr,
    output logic [7:0]    buf_wdata,
    output logic [AW-1:0] buf_raddr,
    output logic          job_valid,
    output job_kind_e     job_kind,
    output logic [7:0]    job_len1,
    output logic [7:0]    job_len2,
    output logic [7:0]    job_addr1,
    output logic [7:0]    job_addr2
);
    localparam logic [8:0] DEPTH9 = 9'(DEPTH);

    typedef struct packed {
        dec_state_e st;
        logic [2:0] bitcnt;
        logic [7:0] rx;
        logic [7:0] tx;
        job_kind_e  kind;
        logic [7:0] len1;
        logic [7:0] len2;
        logic [7:0] addr1;
        logic [7:0] addr2;
        logic [8:0] cnt;
        logic [7:0] idx;
        logic [8:0] ptr;
        logic       complete;
        logic       job_valid;
        logic       stat_set;
        logic       reg_we;
        logic [7:0] reg_wdata;
        logic       buf_we;
        logic [8:0] buf_waddr;
        logic [7:0] buf_wdata;
    } dec_t;

    dec_t d, q;
    logic [7:0] byte_v;
    logic [7:0] resp;
    logic [8:0] len_sum;
    logic       size_bad;

    assign len_sum  = {1'b0, q.len1} + {1'b0, q.len2};
    assign size_bad = ({1'b0, q.len1} > DEPTH9) || ({1'b0, q.len2} > DEPTH9) ||
                      (q.kind == JK_WRWR && len_sum > DEPTH9);

    always_comb begin
        case (q.st)
            ST_REGR_OUT: resp = reg_rdata;
            ST_RDBUF:    resp = (q.ptr < DEPTH9) ? buf_rdata : 8'h00;
            default:     resp = 8'h00;
        endcase
    end

    always_comb begin
        d           = q;
        d.job_valid = 1'b0;
        d.stat_set  = 1'b0;
        d.reg_we    = 1'b0;
        d.buf_we    = 1'b0;
        byte_v      = {q.rx[6:0], mosi_s};
        if (!cs_act) begin
            d.st       = ST_OP;
            d.bitcnt   = 3'd0;
            d.tx       = 8'h00;
            d.complete = 1'b0;
            if (cs_rise && q.complete) begin
                if (size_bad) d.stat_set  = 1'b1;
                else          d.job_valid = 1'b1;
            end
        end else begin
            if (sck_fall) d.tx = (q.bitcnt == 3'd0) ? resp : {q.tx[6:0], 1'b0};
            if (sck_rise) begin
                d.rx     = byte_v;
                d.bitcnt = q.bitcnt + 3'd1;
                if (q.bitcnt == 3'd7) begin
                    case (q.st)
                        ST_OP: begin
                            d.len1  = 8'h00;
                            d.len2  = 8'h00;
                            d.addr2 = 8'h00;
                            case (byte_v)
                                OPC_WR:    begin d.kind = JK_WR;   d.st = ST_LEN1; end
                                OPC_RD:    begin d.kind = JK_RD;   d.st = ST_LEN1; end
                                OPC_WRRD:  begin d.kind = JK_WRRD; d.st = ST_LEN1; end
                                OPC_WRWR:  begin d.kind = JK_WRWR; d.st = ST_LEN1; end
                                OPC_REGW:  d.st = ST_REGW_IDX;
                                OPC_REGR:  d.st = ST_REGR_IDX;
                                OPC_RDBUF: begin d.st = ST_RDBUF; d.ptr = 9'd0; end
                                default:   d.st = ST_IGNORE;
                            endcase
                        end
                        ST_LEN1: begin
                            d.len1 = byte_v;
                            d.st   = (q.kind == JK_WR || q.kind == JK_RD) ? ST_ADDR1 : ST_LEN2;
                        end
                        ST_LEN2: begin
                            d.len2 = byte_v;
                            d.st   = ST_ADDR1;
                        end
                        ST_ADDR1: begin
                            d.addr1 = byte_v;
                            d.cnt   = 9'd0;
                            if (q.kind == JK_RD || (q.kind == JK_WR && q.len1 == 8'd0)) begin
                                d.st       = ST_IGNORE;
                                d.complete = 1'b1;
                            end else if (q.len1 == 8'd0) d.st = ST_ADDR2;
                            else                         d.st = ST_DATA1;
                        end
                        ST_DATA1, ST_DATA2: begin
                            d.cnt = q.cnt + 9'd1;
                            if (q.cnt < DEPTH9) begin
                                d.buf_we    = 1'b1;
                                d.buf_waddr = q.cnt;
                                d.buf_wdata = byte_v;
                            end
                            if (q.st == ST_DATA1 && q.cnt + 9'd1 == {1'b0, q.len1}) begin
                                if (q.kind == JK_WR) begin
                                    d.st       = ST_IGNORE;
                                    d.complete = 1'b1;
                                end else d.st = ST_ADDR2;
                            end
                            if (q.st == ST_DATA2 && q.cnt + 9'd1 == len_sum) begin
                                d.st       = ST_IGNORE;
                                d.complete = 1'b1;
                            end
                        end
                        ST_ADDR2: begin
                            d.addr2 = byte_v;
                            if (q.kind == JK_WRRD || q.len2 == 8'd0) begin
                                d.st       = ST_IGNORE;
                                d.complete = 1'b1;
                            end else d.st = ST_DATA2;
                        end
                        ST_REGW_IDX: begin d.idx = byte_v; d.st = ST_REGW_VAL; end
                        ST_REGW_VAL: begin
                            d.reg_we    = 1'b1;
                            d.reg_wdata = byte_v;
                            d.st        = ST_IGNORE;
                        end
                        ST_REGR_IDX: begin d.idx = byte_v; d.st = ST_REGR_OUT; end
                        ST_REGR_OUT: d.st = ST_IGNORE;
                        ST_RDBUF:    if (q.ptr < DEPTH9) d.ptr = q.ptr + 9'd1;
                        default:     d.st = ST_IGNORE;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_OP;
            q.kind <= JK_WR;
        end else begin
            q <= d;
        end
    end

    assign miso      = q.tx[7];
    assign reg_idx   = q.idx;
    assign reg_we    = q.reg_we;
    assign reg_wdata = q.reg_wdata;
    assign stat_set  = q.stat_set;
    assign buf_we    = q.buf_we;
    assign buf_waddr = q.buf_waddr[AW-1:0];
    assign buf_wdata = q.buf_wdata;
    assign buf_raddr = q.ptr[AW-1:0];
    assign job_valid = q.job_valid;
    assign job_kind  = q.kind;
    assign job_len1  = q.len1;
    assign job_len2  = q.len2;
    assign job_addr1 = q.addr1;
    assign job_addr2 = q.addr2;
endmodule

// File: rtl/spi_cmd_bridge.sv
module spi_cmd_bridge
    import spi_bridge_pkg::*;
#(
    parameter int         DEPTH    = 96,
    parameter int         NREG     = 6,
    parameter int         STAT_IDX = 4,
    parameter logic [7:0] SIZE_ERR = 8'hF9,
    localparam int        AW       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              job_valid,
    output logic [1:0]        job_kind,
    output logic [7:0]        job_len1,
    output logic [7:0]        job_len2,
    output logic [7:0]        job_addr1,
    output logic [7:0]        job_addr2,
    input  logic [AW-1:0]     eng_raddr,
    output logic [7:0]        eng_rdata,
    input  logic              eng_we,
    input  logic [AW-1:0]     eng_waddr,
    input  logic [7:0]        eng_wdata,
    input  logic              stat_we,
    input  logic [7:0]        stat_val,
    output logic [NREG*8-1:0] cfg_regs
);
    logic            sck_rise, sck_fall, cs_act, cs_rise, mosi_s;
    logic [7:0]      reg_idx, reg_wdata, reg_rdata;
    logic            reg_we, stat_set;
    logic            buf_we;
    logic [AW-1:0]   buf_waddr, buf_raddr;
    logic [7:0]      buf_wdata, buf_rdata;
    job_kind_e       kind_w;

    spi_pin_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .csn_i(spi_csn), .mosi_i(spi_mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .cs_rise(cs_rise),
        .mosi_s(mosi_s)
    );

    spi_frame_decoder #(.DEPTH(DEPTH), .AW(AW)) u_dec (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_rise(cs_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
        .reg_rdata(reg_rdata), .buf_rdata(buf_rdata), .miso(spi_miso),
        .reg_idx(reg_idx), .reg_we(reg_we), .reg_wdata(reg_wdata), .stat_set(stat_set),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata), .buf_raddr(buf_raddr),
        .job_valid(job_valid), .job_kind(kind_w), .job_len1(job_len1), .job_len2(job_len2),
        .job_addr1(job_addr1), .job_addr2(job_addr2)
    );
    assign job_kind = kind_w;

    spi_cfg_regs #(.NREG(NREG), .STAT_IDX(STAT_IDX), .SIZE_ERR(SIZE_ERR)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .stat_set(stat_set), .stat_we(stat_we), .stat_val(stat_val),
        .reg_rdata(reg_rdata), .regs_flat(cfg_regs)
    );

    spi_data_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk(clk),
        .a_we(buf_we), .a_waddr(buf_waddr), .a_wdata(buf_wdata),
        .a_raddr(buf_raddr), .a_rdata(buf_rdata),
        .b_we(eng_we), .b_waddr(eng_waddr), .b_wdata(eng_wdata),
        .b_raddr(eng_raddr), .b_rdata(eng_rdata)
    );
endmodule

// File: rtl/spi_cmd_bridge_chk.sv
module spi_cmd_bridge_chk #(
    parameter int DEPTH    = 96,
    parameter int NREG     = 6,
    parameter int STAT_IDX = 4,
    parameter int AW       = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              job_valid,
    input logic [1:0]        job_kind,
    input logic [7:0]        job_len1,
    input logic [7:0]        job_len2,
    input logic              stat_we,
    input logic              stat_set,
    input logic              buf_we,
    input logic [AW-1:0]     buf_waddr,
    input logic [NREG*8-1:0] cfg_regs
);
    // R11
    job_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_valid |=> !job_valid);

    // R7
    job_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_valid |-> (int'(job_len1) <= DEPTH && int'(job_len2) <= DEPTH));

    // R7
    job_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (job_valid && job_kind == 2'd3) |-> (int'(job_len1) + int'(job_len2) <= DEPTH));

    // R2
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_we && !stat_set) |=> $stable(cfg_regs[STAT_IDX*8 +: 8]));

    // R7
    stat_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_set |-> !job_valid);

    // R6
    buf_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> int'(buf_waddr) < DEPTH);
endmodule

bind spi_cmd_bridge spi_cmd_bridge_chk #(
    .DEPTH(DEPTH), .NREG(NREG), .STAT_IDX(STAT_IDX), .AW(AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_kind(job_kind),
    .job_len1(job_len1), .job_len2(job_len2), .stat_we(stat_we), .stat_set(stat_set),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .cfg_regs(cfg_regs)
);

// File: tb/sim_spi_cmd_bridge.sv
`timescale 1ns/1ps
module sim_spi_cmd_bridge;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b1, spi_csn = 1'b1, spi_mosi = 1'b0;
    logic        spi_miso;
    logic        job_valid;
    logic [1:0]  job_kind;
    logic [7:0]  job_len1, job_len2, job_addr1, job_addr2;
    logic [6:0]  eng_raddr = '0;
    logic [7:0]  eng_rdata;
    logic        eng_we = 1'b0;
    logic [6:0]  eng_waddr = '0;
    logic [7:0]  eng_wdata = '0;
    logic        stat_we = 1'b0;
    logic [7:0]  stat_val = '0;
    logic [47:0] cfg_regs;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [33:0] exp_q [$];
    logic [7:0]  tx_q [$];
    logic [7:0]  rx_q [$];

    always #4 clk = ~clk;

    spi_cmd_bridge u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .job_valid(job_valid), .job_kind(job_kind),
        .job_len1(job_len1), .job_len2(job_len2), .job_addr1(job_addr1), .job_addr2(job_addr2),
        .eng_raddr(eng_raddr), .eng_rdata(eng_rdata), .eng_we(eng_we), .eng_waddr(eng_waddr),
        .eng_wdata(eng_wdata), .stat_we(stat_we), .stat_val(stat_val), .cfg_regs(cfg_regs)
    );

    task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pop and compare every job pulse
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n && job_valid) begin
            if (prev_valid) check("R11 pulse longer than one cycle", 34'd1, 34'd0);
            else if (exp_q.size() == 0) check("R8 unexpected job", {job_kind, job_len1, job_len2, job_addr1, job_addr2}, 34'd0);
            else check("R3-job fields", {job_kind, job_len1, job_len2, job_addr1, job_addr2}, exp_q.pop_front());
        end
        prev_valid <= job_valid;
    end

    task automatic push_job(input logic [1:0] k, input logic [7:0] l1, l2, a1, a2);
        exp_q.push_back({k, l1, l2, a1, a2});
    endtask

    task automatic run_frame(input int nbytes);
        rx_q.delete();
        spi_csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < nbytes; b++) begin
            logic [7:0] t, r;
            t = tx_q[b];
            for (int i = 7; i >= 0; i--) begin
                spi_sck = 1'b0;
                spi_mosi = t[i];
                repeat (HALF) @(negedge clk);
                r[i] = spi_miso;
                spi_sck = 1'b1;
                repeat (HALF) @(negedge clk);
            end
            rx_q.push_back(r);
        end
        repeat (HALF) @(negedge clk);
        spi_csn = 1'b1;
        repeat (2*HALF) @(negedge clk);
        tx_q.delete();
    endtask

    task automatic jobs_drained(input string req);
        check(req, 34'(exp_q.size()), 34'd0);
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] val);
        tx_q = '{8'h21, idx, 8'h00};
        run_frame(3);
        val = rx_q[2];
    endtask

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // reset state
        check("R10 reset miso", 34'(spi_miso), 34'd0);
        check("R11 reset job_valid", 34'(job_valid), 34'd0);
        check("R1 reset regs", 34'(cfg_regs[31:0]), 34'd0);

        // R1 register write then read
        tx_q = '{8'h20, 8'h02, 8'hA5};
        run_frame(3);
        check("R1 cfg byte 2", 34'(cfg_regs[23:16]), 34'hA5);
        reg_read(8'h02, v);
        check("R1 read back", 34'(v), 34'hA5);
        check("R10 opcode byte miso", 34'(rx_q[0]), 34'd0);

        // R2 status write ignored
        tx_q = '{8'h20, 8'h04, 8'h55};
        run_frame(3);
        reg_read(8'h04, v);
        check("R2 status unwritable", 34'(v), 34'h00);
        @(negedge clk); stat_we = 1'b1; stat_val = 8'hF0;
        @(negedge clk); stat_we = 1'b0;
        reg_read(8'h04, v);
        check("R2 engine status", 34'(v), 34'hF0);

        // R10 out-of-range register
        reg_read(8'h07, v);
        check("R10 unknown index", 34'(v), 34'h00);

        // R3 write
        push_job(2'd0, 8'd3, 8'd0, 8'h84, 8'd0);
        tx_q = '{8'h00, 8'h03, 8'h84, 8'h11, 8'h22, 8'h33};
        run_frame(6);
        jobs_drained("R3 job issued");
        eng_raddr = 7'd0; #1 check("R3 buf0", 34'(eng_rdata), 34'h11);
        eng_raddr = 7'd2; #1 check("R3 buf2", 34'(eng_rdata), 34'h33);

        // R4 read
        push_job(2'd1, 8'd5, 8'd0, 8'hA1, 8'd0);
        tx_q = '{8'h01, 8'h05, 8'hA1};
        run_frame(3);
        jobs_drained("R4 job issued");

        // R5 write then read
        push_job(2'd2, 8'd2, 8'd4, 8'h50, 8'h51);
        tx_q = '{8'h02, 8'h02, 8'h04, 8'h50, 8'hAA, 8'hBB, 8'h51};
        run_frame(7);
        jobs_drained("R5 job issued");
        eng_raddr = 7'd1; #1 check("R5 buf1", 34'(eng_rdata), 34'hBB);

        // R6 write then write
        push_job(2'd3, 8'd1, 8'd2, 8'h60, 8'h62);
        tx_q = '{8'h03, 8'h01, 8'h02, 8'h60, 8'hC1, 8'h62, 8'hD1, 8'hD2};
        run_frame(8);
        jobs_drained("R6 job issued");
        eng_raddr = 7'd0; #1 check("R6 buf0", 34'(eng_rdata), 34'hC1);
        eng_raddr = 7'd1; #1 check("R6 buf1", 34'(eng_rdata), 34'hD1);
        eng_raddr = 7'd2; #1 check("R6 buf2", 34'(eng_rdata), 34'hD2);

        // R8 partial frame: status stays 0xF0
        tx_q = '{8'h00, 8'h03, 8'h20, 8'h01};
        run_frame(4);
        reg_read(8'h04, v);
        check("R8 status unchanged", 34'(v), 34'hF0);

        // R7 oversize single write
        tx_q.delete();
        tx_q.push_back(8'h00); tx_q.push_back(8'd97); tx_q.push_back(8'h10);
        for (int i = 0; i < 97; i++) tx_q.push_back(8'(i));
        run_frame(100);
        reg_read(8'h04, v);
        check("R7 size error status", 34'(v), 34'hF9);

        // R7 oversize sum for write-then-write
        @(negedge clk); stat_we = 1'b1; stat_val = 8'hF0;
        @(negedge clk); stat_we = 1'b0;
        tx_q.delete();
        tx_q.push_back(8'h03); tx_q.push_back(8'd60); tx_q.push_back(8'd40); tx_q.push_back(8'h20);
        for (int i = 0; i < 60; i++) tx_q.push_back(8'h00);
        tx_q.push_back(8'h22);
        for (int i = 0; i < 40; i++) tx_q.push_back(8'h00);
        run_frame(105);
        reg_read(8'h04, v);
        check("R7 sum size error", 34'(v), 34'hF9);

        // R9 buffer read of engine data
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); eng_we = 1'b1; eng_waddr = 7'(i); eng_wdata = 8'(8'h70 + i);
        end
        @(negedge clk); eng_we = 1'b0;
        tx_q = '{8'h06, 8'h00, 8'h00, 8'h00, 8'h00};
        run_frame(5);
        check("R10 rdbuf opcode miso", 34'(rx_q[0]), 34'd0);
        for (int i = 0; i < 4; i++) check("R9 buffer byte", 34'(rx_q[i+1]), 34'(8'h70 + i));

        jobs_drained("R11 no stray jobs");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule